// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch is taken by running two direction predictors side by side and choosing between them for each branch. One component is a bimodal table of 2-bit saturating counters addressed by low bits of the branch address. The other is a table of 2-bit saturating counters addressed by a global history register, which holds the outcomes of the most recent resolved branches. A third table of 2-bit saturating counters is also addressed by the global history and decides which component's prediction is used.

The fetch side presents a branch address and reads the final prediction combinationally, together with both component predictions and the selector decision. When the branch resolves, the execute side presents the address, the real outcome and the two component predictions that were made for it. Both components are trained toward the outcome. The selector is trained only when exactly one component was right, and it moves toward that component. The history register then shifts in the outcome.

After reset a small state machine walks every table entry and writes its start value. It has two states. ST_SWEEP clears one index per cycle. The transition sweep_done goes from ST_SWEEP to ST_RUN when the last index has been cleared. ST_RUN holds until the next reset. The output `ready` is high only in ST_RUN.

Top module: `tournament_predictor`

## Requirements
- R1: After reset is released, `ready` stays low for exactly 2^max(BIM_W,HIST_W) rising clock edges. It goes high after the last of these edges and stays high until the next reset.
- R2: Once `ready` rises, every bimodal and global counter holds 10 (weakly taken), so `pred_bim` and `pred_glb` read 1. Every selector counter holds 01, so `pred_use_bim` reads 0.
- R3: `pred_bim` is the MSB of the bimodal counter at index `pred_pc[BIM_W+1:2]`.
- R4: `pred_glb` is the MSB of the global counter at index equal to the current global history.
- R5: `pred_use_bim` is the MSB of the selector counter indexed by the global history. `pred_final` equals `pred_bim` when that bit is 1 and `pred_glb` when it is 0.
- R6: A resolution applies when `res_valid` and `ready` are both high. It increments (taken) or decrements (not taken) the bimodal counter at `res_pc[BIM_W+1:2]` and the global counter at the current history. Both counters saturate at 11 and 00.
- R7: At a resolution, the selector counter at the current history increments (saturating at 11) when `res_bim` equals the outcome and `res_glb` does not. It decrements (saturating at 00) in the opposite case. It is left unchanged when both components were right or both were wrong.
- R8: The global history resets to all zeros. At each resolution it shifts left by one and takes `res_taken` into bit 0. All table and history changes become visible from the next cycle.
- R9: Without a resolution no counter and no history bit changes, so the predictions for any address repeat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ready | output | 1 | High once the tables are initialised |
| pred_pc | input | PC_W | Address of the branch being predicted |
| pred_final | output | 1 | Selected direction, 1 = taken |
| pred_bim | output | 1 | Bimodal component prediction |
| pred_glb | output | 1 | Global component prediction |
| pred_use_bim | output | 1 | 1 when the bimodal prediction is selected |
| res_valid | input | 1 | A branch resolves this cycle |
| res_pc | input | PC_W | Address of the resolving branch |
| res_taken | input | 1 | Actual outcome, 1 = taken |
| res_bim | input | 1 | Bimodal prediction made earlier for this branch |
| res_glb | input | 1 | Global prediction made earlier for this branch |

## Verification
The assertions assume that a branch resolves before the next branch is predicted. The history seen at prediction is then the history used for training, and a component counter is only moved by outcomes of branches in the order they resolve. They also assume that `res_bim` and `res_glb` carry the component predictions that were actually read out for that branch. The stimulus predicts and resolves one branch per cycle with exactly those values. It never drives a resolution while `ready` is low, and it puts idle cycles between resolutions to show that the state holds.

// File: rtl/tp_pkg.sv
package tp_pkg;

    typedef logic [1:0] ctr2_t;

    typedef enum logic {
        ST_SWEEP = 1'b0,
        ST_RUN   = 1'b1
    } tp_state_e;

    function automatic ctr2_t ctr_next(ctr2_t cur, logic up);
        ctr2_t nxt;
        if (up) nxt = (cur == 2'b11) ? cur : cur + 2'd1;
        else    nxt = (cur == 2'b00) ? cur : cur - 2'd1;
        return nxt;
    endfunction

endpackage

// File: rtl/tp_init_seq.sv
module tp_init_seq
    import tp_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic             clr_en,
    output logic [IDX_W-1:0] clr_idx,
    output logic             ready
);
    localparam logic [IDX_W-1:0] LAST_IDX = {IDX_W{1'b1}};

    tp_state_e state_q, state_d;
    logic [IDX_W-1:0] idx_q;

    // state register and sweep index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SWEEP;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_SWEEP) idx_q <= idx_q + 1'b1;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SWEEP: if (idx_q == LAST_IDX) state_d = ST_RUN;  // sweep_done
            ST_RUN:   state_d = ST_RUN;
            default:  state_d = ST_SWEEP;
        endcase
    end

    // outputs
    always_comb begin
        clr_en  = 1'b0;
        ready   = 1'b0;
        clr_idx = idx_q;
        unique case (state_q)
            ST_SWEEP: clr_en = 1'b1;
            ST_RUN:   ready  = 1'b1;
            default:  clr_en = 1'b0;
        endcase
    end

endmodule

// File: rtl/tp_sat_table.sv
module tp_sat_table
    import tp_pkg::*;
#(
    parameter int    IDX_W    = 10,
    parameter ctr2_t INIT_VAL = 2'b10
) (
    input  logic             clk,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] clr_idx,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_msb,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_up
);
    localparam int DEPTH = 1 << IDX_W;

    ctr2_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (clr_en)     mem[clr_idx] <= INIT_VAL;
        else if (wr_en) mem[wr_idx]  <= ctr_next(mem[wr_idx], wr_up);
    end

    assign rd_msb = mem[rd_idx][1];

endmodule

// File: rtl/tp_hist_reg.sv
module tp_hist_reg #(
    parameter int HIST_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              bit_in,
    output logic [HIST_W-1:0] hist
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        hist <= '0;
        else if (shift_en) hist <= {hist[HIST_W-2:0], bit_in};
    end
endmodule

// File: rtl/tournament_predictor.sv
module tournament_predictor
    import tp_pkg::*;
#(
    parameter int PC_W   = 32,
    parameter int BIM_W  = 10,
    parameter int HIST_W = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic            ready,
    input  logic [PC_W-1:0] pred_pc,
    output logic            pred_final,
    output logic            pred_bim,
    output logic            pred_glb,
    output logic            pred_use_bim,
    input  logic            res_valid,
    input  logic [PC_W-1:0] res_pc,
    input  logic            res_taken,
    input  logic            res_bim,
    input  logic            res_glb
);
    localparam int SW_W = (BIM_W > HIST_W) ? BIM_W : HIST_W;

    logic              clr_en;
    logic [SW_W-1:0]   clr_idx;
    logic [HIST_W-1:0] ghr;
    logic              upd, bim_ok, glb_ok, cho_msb;
    logic              unused_pc_bits;

    assign unused_pc_bits = ^{pred_pc[PC_W-1:BIM_W+2], pred_pc[1:0],
                              res_pc[PC_W-1:BIM_W+2], res_pc[1:0]};

    assign upd    = res_valid & ready;
    assign bim_ok = (res_bim == res_taken);
    assign glb_ok = (res_glb == res_taken);

    tp_init_seq #(.IDX_W(SW_W)) u_init (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_en  (clr_en),
        .clr_idx (clr_idx),
        .ready   (ready)
    );

    tp_hist_reg #(.HIST_W(HIST_W)) u_ghr (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (upd),
        .bit_in   (res_taken),
        .hist     (ghr)
    );

    tp_sat_table #(.IDX_W(BIM_W), .INIT_VAL(2'b10)) u_bim (
        .clk     (clk),
        .clr_en  (clr_en),
        .clr_idx (clr_idx[BIM_W-1:0]),
        .rd_idx  (pred_pc[BIM_W+1:2]),
        .rd_msb  (pred_bim),
        .wr_en   (upd),
        .wr_idx  (res_pc[BIM_W+1:2]),
        .wr_up   (res_taken)
    );

    tp_sat_table #(.IDX_W(HIST_W), .INIT_VAL(2'b10)) u_glb (
        .clk     (clk),
        .clr_en  (clr_en),
        .clr_idx (clr_idx[HIST_W-1:0]),
        .rd_idx  (ghr),
        .rd_msb  (pred_glb),
        .wr_en   (upd),
        .wr_idx  (ghr),
        .wr_up   (res_taken)
    );

    // selector: trained only when the components differ in correctness
    tp_sat_table #(.IDX_W(HIST_W), .INIT_VAL(2'b01)) u_cho (
        .clk     (clk),
        .clr_en  (clr_en),
        .clr_idx (clr_idx[HIST_W-1:0]),
        .rd_idx  (ghr),
        .rd_msb  (cho_msb),
        .wr_en   (upd & (bim_ok ^ glb_ok)),
        .wr_idx  (ghr),
        .wr_up   (bim_ok)
    );

    assign pred_use_bim = cho_msb;
    assign pred_final   = cho_msb ? pred_bim : pred_glb;

endmodule

// File: rtl/tp_checker.sv
module tp_checker #(
    parameter int HIST_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ready,
    input logic              res_valid,
    input logic              res_taken,
    input logic [HIST_W-1:0] hist,
    input logic              pred_bim,
    input logic              pred_glb,
    input logic              pred_final
);
    // R1: once ready, stays ready
    a_r1_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);

    // R5: when components agree the final prediction is that value
    a_r5_agree_final: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && (pred_bim == pred_glb)) |-> (pred_final == pred_bim));

    // R8: history shifts the outcome in at each resolution
    a_r8_hist_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && res_valid) |=>
            (hist == {$past(hist[HIST_W-2:0]), $past(res_taken)}));

    // R9: no resolution leaves the history unchanged
    a_r9_hist_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(ready && res_valid) |=> $stable(hist));
endmodule

bind tournament_predictor tp_checker #(.HIST_W(HIST_W)) u_tp_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .ready      (ready),
    .res_valid  (res_valid),
    .res_taken  (res_taken),
    .hist       (ghr),
    .pred_bim   (pred_bim),
    .pred_glb   (pred_glb),
    .pred_final (pred_final)
);

// File: tb/test_tournament_predictor.sv
module test_tournament_predictor;
    localparam int PC_W   = 32;
    localparam int BIM_W  = 10;
    localparam int HIST_W = 10;
    localparam int BIM_D  = 1 << BIM_W;
    localparam int HD     = 1 << HIST_W;
    localparam int SWEEP  = (BIM_D > HD) ? BIM_D : HD;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            ready;
    logic [PC_W-1:0] pred_pc = '0;
    logic            pred_final, pred_bim, pred_glb, pred_use_bim;
    logic            res_valid = 1'b0;
    logic [PC_W-1:0] res_pc = '0;
    logic            res_taken = 1'b0, res_bim = 1'b0, res_glb = 1'b0;

    int bim_m [BIM_D];
    int glb_m [HD];
    int cho_m [HD];
    int ghr_m = 0;
    int checks = 0, fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    tournament_predictor #(.PC_W(PC_W), .BIM_W(BIM_W), .HIST_W(HIST_W))
    i_tournament_predictor (
        .clk(clk), .rst_n(rst_n), .ready(ready), .pred_pc(pred_pc),
        .pred_final(pred_final), .pred_bim(pred_bim), .pred_glb(pred_glb),
        .pred_use_bim(pred_use_bim), .res_valid(res_valid), .res_pc(res_pc),
        .res_taken(res_taken), .res_bim(res_bim), .res_glb(res_glb)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int sat(int c, bit up);
        if (up) return (c == 3) ? 3 : c + 1;
        return (c == 0) ? 0 : c - 1;
    endfunction

    // predict pc, compare, then optionally resolve it with outcome t
    task automatic step(logic [PC_W-1:0] pc, bit t, bit v, string note);
        int bi, gi;
        bit eb, eg, ec;
        @(negedge clk);
        res_valid = 1'b0;
        pred_pc = pc;
        #1;
        bi = int'((pc >> 2) % BIM_D);
        gi = ghr_m;
        eb = bim_m[bi] >= 2;
        eg = glb_m[gi] >= 2;
        ec = cho_m[gi] >= 2;
        chk({"R3/R6 pred_bim ", note}, pred_bim, eb);
        chk({"R4/R6/R8 pred_glb ", note}, pred_glb, eg);
        chk({"R7 pred_use_bim ", note}, pred_use_bim, ec);
        chk({"R5 pred_final ", note}, pred_final, ec ? eb : eg);
        res_valid = v; res_pc = pc; res_taken = t; res_bim = eb; res_glb = eg;
        @(posedge clk);
        if (v) begin
            if ((eb == t) && (eg != t)) cho_m[gi] = sat(cho_m[gi], 1'b1);
            if ((eb != t) && (eg == t)) cho_m[gi] = sat(cho_m[gi], 1'b0);
            bim_m[bi] = sat(bim_m[bi], t);
            glb_m[gi] = sat(glb_m[gi], t);
            ghr_m = ((ghr_m << 1) | int'(t)) & (HD - 1);
        end
        #1 res_valid = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int n;
        bit r;
        foreach (bim_m[i]) bim_m[i] = 2;
        foreach (glb_m[i]) glb_m[i] = 2;
        foreach (cho_m[i]) cho_m[i] = 1;

        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1 chk("R1 ready low after reset", ready, 0);
        n = 0;
        while (!ready && n < SWEEP + 10) begin
            @(posedge clk); n++; #1;
        end
        chk("R1 sweep length", n, SWEEP);
        chk("R1 ready high", ready, 1);

        @(negedge clk);
        pred_pc = 32'h0000_0040; #1;
        chk("R2 init pred_bim", pred_bim, 1);
        chk("R2 init pred_glb", pred_glb, 1);
        chk("R2 init pred_use_bim", pred_use_bim, 0);

        for (int i = 0; i < 24; i++) step(32'h100, i[0], 1'b1, "alternating");
        for (int i = 0; i < 40; i++) step(32'h204, (i % 4) != 3, 1'b1, "loop");
        for (int i = 0; i < 40; i++) begin
            r = $urandom_range(1);
            step(32'h300, r, 1'b1, "corr-a");
            step(32'h304, r, 1'b1, "corr-b");
        end
        for (int i = 0; i < 10; i++) begin
            step(32'h204, 1'b0, 1'b0, "R9 idle");
            step(32'h204, 1'b0, 1'b0, "R9 repeat");
        end
        for (int i = 0; i < 30; i++) begin
            step(32'h100, 1'b1, 1'b1, "alias-a");
            step(32'h100 + 4 * BIM_D, 1'b0, 1'b1, "alias-b");
        end
        for (int i = 0; i < 30; i++) step(32'h80, 1'b1, 1'b1, "saturate-up");
        for (int i = 0; i < 30; i++) step(32'h80, 1'b0, 1'b1, "saturate-down");
        for (int i = 0; i < 400; i++) begin
            step({$urandom_range(63), 2'b00}, $urandom_range(3) != 0,
                 $urandom_range(7) != 0, "random");
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule